// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block gives software a single memory-mapped control word through which it reaches a small bank of 8-bit PHY delay registers. Software never addresses the delay registers directly. It loads a target address and a data byte into the control word, then raises either a write request or a read request. It waits for the acknowledge flag and then drops the request. The block carries each request to a modelled PHY register bank, which takes a parameterised number of cycles to complete an access. For reads, the fetched byte is returned in a read-data field of the same word.

The handshake is a strict four-phase one, run by a four-state machine:
- IDLE: waits for exactly one request bit. It moves to ACCESS (IDLE→ACCESS) and issues the access.
- IDLE→FAULT: taken when both request bits are set together.
- ACCESS: waits for the bank to report completion (ACCESS→ACK).
- ACK: drives acknowledge high until both request bits are low (ACK→IDLE).
- FAULT: raises no acknowledge and performs no access. It returns to IDLE once both request bits are low (FAULT→IDLE).

Delay slots exist at PHY addresses 0x00–0x08 and 0x0B–0x0D. Every other address reads as zero and discards writes, but its handshake still completes.

Top module: `phy_port_top`

## Requirements
- R1: After reset, the control word reads as all zeros.
- R2: The control word is at byte offset 0x10 of the register window, and any other offset reads as zero and ignores writes. The word's fields are:
  - bits [7:0]: PHY address
  - bits [15:8]: write byte
  - bits [23:16]: read byte
  - bit 24: write request
  - bit 25: read request
  - bit 26: acknowledge

  Bits [23:16] and bit 26 cannot be written by software.
- R3: Acknowledge rises only after the PHY-side access has completed.
- R4: Acknowledge stays high for as long as a request bit stays set.
- R5: Acknowledge falls on the second clock edge after the bus write that clears the last request bit. It is therefore low one cycle after the cleared request becomes visible in the word.
- R6: A completed write stores its byte in the addressed delay slot (0x00–0x08, 0x0B–0x0D), and a later read of that address returns it in bits [23:16].
- R7: The read-byte field changes only when a read completes, and it holds its value across writes and other activity.
- R8: Setting both request bits at once performs no access and never raises acknowledge.
- R9: A new request set while acknowledge is still high is ignored. No access takes place for it.
- R10: Addresses 0x09, 0x0A and 0x0E–0xFF read as zero and ignore writes, yet still receive an acknowledge.
- R11: With access latency LATENCY, acknowledge becomes visible exactly LATENCY+1 clock edges after the edge at which the bus write setting the request takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (10) | Byte offset in the register window |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |

## Verification
The hardest situation to reach is a second request that arrives while acknowledge is still high from the first. To set it up, the stimulus completes a write and keeps the write request set. With acknowledge still high, it rewrites the word to carry a read request for another address. It then confirms three things: acknowledge stays high, it falls only once both bits clear, and the read-byte field never moves. The both-bits fault is produced with a single bus write that sets both request bits. The bench then shows that acknowledge stays low for longer than the access latency and that the targeted slot keeps its old value.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_ACK    = 2'd2,
        ST_FAULT  = 2'd3
    } hs_state_t;

    localparam int FLD_ADDR_LSB  = 0;
    localparam int FLD_WDATA_LSB = 8;
    localparam int FLD_RDATA_LSB = 16;
    localparam int BIT_WREQ      = 24;
    localparam int BIT_RREQ      = 25;
    localparam int BIT_ACK       = 26;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        logic       is_read;
    } phy_cmd_t;

    function automatic logic slot_present(input logic [7:0] a);
        return (a <= 8'h08) || ((a >= 8'h0b) && (a <= 8'h0d));
    endfunction

endpackage

// File: rtl/phy_port_hostreg.sv
module phy_port_hostreg
    import phy_port_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int HOST_OFS = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ack,
    input  logic              rd_done,
    input  logic [7:0]        rd_byte,
    output logic [7:0]        cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              wr_req,
    output logic              rd_req
);

    localparam logic [ADDR_W-1:0] HIT_OFS = ADDR_W'(HOST_OFS);

    logic       hit;
    logic [7:0] rd_field;
    logic [31:0] word;

    assign hit = (bus_addr == HIT_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_addr <= '0;
            cmd_data <= '0;
            wr_req   <= 1'b0;
            rd_req   <= 1'b0;
        end else if (bus_wr && hit) begin
            cmd_addr <= bus_wdata[FLD_ADDR_LSB +: 8];
            cmd_data <= bus_wdata[FLD_WDATA_LSB +: 8];
            wr_req   <= bus_wdata[BIT_WREQ];
            rd_req   <= bus_wdata[BIT_RREQ];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_field <= '0;
        end else if (rd_done) begin
            rd_field <= rd_byte;
        end
    end

    always_comb begin
        word = '0;
        word[FLD_ADDR_LSB  +: 8] = cmd_addr;
        word[FLD_WDATA_LSB +: 8] = cmd_data;
        word[FLD_RDATA_LSB +: 8] = rd_field;
        word[BIT_WREQ]           = wr_req;
        word[BIT_RREQ]           = rd_req;
        word[BIT_ACK]            = ack;
    end

    assign bus_rdata = hit ? word : 32'h0;

    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[31:27], bus_wdata[26], bus_wdata[23:16]};

    // R7: read byte moves only on a completed read
    a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> $stable(rd_field));

    // R2: writes away from the control word leave it untouched
    a_r2_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> ($stable(cmd_addr) && $stable(cmd_data)
                              && $stable(wr_req) && $stable(rd_req)));

endmodule

// File: rtl/phy_port_fsm.sv
module phy_port_fsm
    import phy_port_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic rd_req,
    input  logic bank_done,
    input  logic bank_busy,
    output logic start,
    output logic start_read,
    output logic ack
);

    localparam int ACC_W = 16;

    hs_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_req && rd_req)      nxt = ST_FAULT;
                else if (wr_req || rd_req) nxt = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (bank_done) nxt = ST_ACK;
            end
            ST_ACK: begin
                if (!wr_req && !rd_req) nxt = ST_IDLE;
            end
            ST_FAULT: begin
                if (!wr_req && !rd_req) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        start      = 1'b0;
        start_read = 1'b0;
        ack        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                start      = wr_req ^ rd_req;
                start_read = rd_req;
            end
            ST_ACK:    ack = 1'b1;
            ST_ACCESS,
            ST_FAULT:  ;
            default:   ;
        endcase
    end

    // cycles spent in ACCESS, kept only for the latency check
    logic [ACC_W-1:0] acc_cycles;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      acc_cycles <= '0;
        else if (state != ST_ACCESS)     acc_cycles <= '0;
        else if (acc_cycles != '1)       acc_cycles <= acc_cycles + 1'b1;
    end

    // R3, R11: acknowledge waits for the full access latency
    a_r3_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && bank_done) |-> (32'(acc_cycles) >= LATENCY - 1));

    // R4: acknowledge held while a request is held
    a_r4_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (wr_req || rd_req)) |=> ack);

    // R5: acknowledge falls one cycle after the requests clear
    a_r5_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr_req && !rd_req) |=> !ack);

    // R8: both requests together give no access and no acknowledge
    a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_req && rd_req) |=> (!ack && !bank_busy));

    // R9: no access launched while acknowledge is high
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !bank_done);

endmodule

// File: rtl/phy_port_bank.sv
module phy_port_bank
    import phy_port_pkg::*;
#(
    parameter int LATENCY  = 3,
    parameter int SLOT_CNT = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_read,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       done,
    output logic       busy,
    output logic       rd_done,
    output logic [7:0] rd_byte
);

    localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

    logic [CNT_W-1:0] cnt;
    phy_cmd_t         cmd;
    logic [7:0]       slot_q [SLOT_CNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            cmd  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= CNT_LOAD;
            cmd  <= '{addr: addr, data: wdata, is_read: start_read};
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done    = busy && (cnt == '0);
    assign rd_done = done && cmd.is_read;

    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
        if (slot_present(8'(g))) begin : g_real
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    slot_q[g] <= '0;
                else if (done && !cmd.is_read && cmd.addr == 8'(g))
                    slot_q[g] <= cmd.data;
            end
        end else begin : g_hole
            assign slot_q[g] = '0;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < SLOT_CNT; i++) begin
            if (cmd.addr == 8'(i)) rd_byte = slot_q[i];
        end
    end

    // R10: unmapped addresses return zero
    a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !slot_present(cmd.addr)) |-> (rd_byte == 8'h00));

    // R3: an accepted request keeps the bank busy next cycle
    a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: rtl/phy_port_top.sv
module phy_port_top
    import phy_port_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int HOST_OFS = 'h10,
    parameter int LATENCY  = 3,
    parameter int SLOT_CNT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    logic       ack, wr_req, rd_req;
    logic       start, start_read;
    logic       bank_done, bank_busy, rd_done;
    logic [7:0] cmd_addr, cmd_data, rd_byte;

    phy_port_hostreg #(
        .ADDR_W   (ADDR_W),
        .HOST_OFS (HOST_OFS)
    ) u_hostreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ack       (ack),
        .rd_done   (rd_done),
        .rd_byte   (rd_byte),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .wr_req    (wr_req),
        .rd_req    (rd_req)
    );

    phy_port_fsm #(
        .LATENCY (LATENCY)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .rd_req     (rd_req),
        .bank_done  (bank_done),
        .bank_busy  (bank_busy),
        .start      (start),
        .start_read (start_read),
        .ack        (ack)
    );

    phy_port_bank #(
        .LATENCY  (LATENCY),
        .SLOT_CNT (SLOT_CNT)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_read (start_read),
        .addr       (cmd_addr),
        .wdata      (cmd_data),
        .done       (bank_done),
        .busy       (bank_busy),
        .rd_done    (rd_done),
        .rd_byte    (rd_byte)
    );

endmodule

// File: tb/phy_port_top_tb_top.sv
module phy_port_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int LAT        = 3;
    localparam logic [ADDR_W-1:0] HOST = 10'h010;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = HOST;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_port_top #(.ADDR_W(ADDR_W), .LATENCY(LAT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = HOST;
    endtask

    function automatic logic ack_now();
        return bus_rdata[26];
    endfunction

    // full four-phase transfer with timing checks
    task automatic xfer(input bit is_rd, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] exp_rd, input string req);
        logic [31:0] w;
        int waits;
        w = {16'h0, d, a};
        bus_write(HOST, w);
        if (is_rd) exp_q.push_back(exp_rd);
        bus_write(HOST, w | (is_rd ? 32'h0200_0000 : 32'h0100_0000));
        waits = 0;
        while (!ack_now() && waits < 100) begin
            @(negedge clk);
            waits++;
        end
        chk(waits == LAT + 1, {req, " R11 ack timing"}, waits, LAT + 1);
        repeat (2) @(negedge clk);
        chk(ack_now() == 1'b1, {req, " R4 ack held"}, ack_now(), 1);
        bus_write(HOST, w);
        @(negedge clk);
        chk(ack_now() == 1'b0, {req, " R5 ack drop"}, ack_now(), 0);
        if (is_rd)
            chk(bus_rdata[23:16] == exp_rd, {req, " read byte"}, bus_rdata[23:16], exp_rd);
    endtask

    // scoreboard monitor: compare read byte when a read acknowledge rises
    initial begin
        logic prev_ack;
        logic [7:0] e;
        prev_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && bus_addr == HOST && !bus_wr) begin
                if (bus_rdata[26] && !prev_ack && bus_rdata[25]) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R6 scoreboard unexpected read", bus_rdata[23:16], 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(bus_rdata[23:16] == e, "R6 scoreboard read",
                            bus_rdata[23:16], e);
                    end
                end
                prev_ack = bus_rdata[26];
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        chk(bus_rdata == 32'h0, "R1 reset word", bus_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 field layout readback
        bus_write(HOST, 32'h0000_A705);
        chk(bus_rdata[15:0] == 16'hA705 && bus_rdata[26:24] == 3'b000,
            "R2 field readback", bus_rdata, 32'h0000_A705);

        // R6 write / read of mapped slots, including edges of both ranges
        xfer(0, 8'h03, 8'h5A, 8'h00, "R6 wr 03");
        xfer(1, 8'h03, 8'h00, 8'h5A, "R6 rd 03");
        xfer(0, 8'h0d, 8'hC3, 8'h00, "R6 wr 0d");
        xfer(0, 8'h00, 8'h11, 8'h00, "R6 wr 00");
        xfer(0, 8'h08, 8'h80, 8'h00, "R6 wr 08");
        xfer(0, 8'h0b, 8'h3C, 8'h00, "R6 wr 0b");
        xfer(1, 8'h00, 8'h00, 8'h11, "R6 rd 00");
        xfer(1, 8'h08, 8'h00, 8'h80, "R6 rd 08");
        xfer(1, 8'h0b, 8'h00, 8'h3C, "R6 rd 0b");

        // R10 holes: writes dropped, reads zero, handshake completes
        xfer(0, 8'h09, 8'hFF, 8'h00, "R10 wr 09");
        xfer(0, 8'h0e, 8'h77, 8'h00, "R10 wr 0e");
        xfer(0, 8'hFF, 8'h55, 8'h00, "R10 wr ff");
        xfer(1, 8'h09, 8'h00, 8'h00, "R10 rd 09");
        xfer(1, 8'h0e, 8'h00, 8'h00, "R10 rd 0e");
        xfer(1, 8'hFF, 8'h00, 8'h00, "R10 rd ff");

        // R7 read byte holds across a write
        xfer(1, 8'h0d, 8'h00, 8'hC3, "R7 rd 0d");
        xfer(0, 8'h00, 8'h22, 8'h00, "R7 wr 00");
        chk(bus_rdata[23:16] == 8'hC3, "R7 hold after write", bus_rdata[23:16], 8'hC3);

        // R8 both requests: no ack, no access
        bus_write(HOST, 32'h0300_9903);
        begin
            bit seen;
            seen = 0;
            for (int i = 0; i < LAT + 5; i++) begin
                @(negedge clk);
                if (ack_now()) seen = 1;
            end
            chk(!seen, "R8 no ack on double request", seen, 0);
        end
        bus_write(HOST, 32'h0000_0003);
        xfer(1, 8'h03, 8'h00, 8'h5A, "R8 slot unchanged");

        // R9 new request while ack high is ignored
        keep = bus_rdata[23:16];
        bus_write(HOST, 32'h0000_4B0C);
        bus_write(HOST, 32'h0100_4B0C);
        repeat (LAT + 3) @(negedge clk);
        chk(ack_now() == 1'b1, "R9 first ack", ack_now(), 1);
        bus_write(HOST, 32'h0200_000D);
        repeat (LAT + 3) @(negedge clk);
        chk(ack_now() == 1'b1, "R9 ack stays during second request", ack_now(), 1);
        chk(bus_rdata[23:16] == keep, "R9 no read performed", bus_rdata[23:16], keep);
        bus_write(HOST, 32'h0000_000D);
        @(negedge clk);
        chk(ack_now() == 1'b0, "R9 ack falls", ack_now(), 0);
        chk(bus_rdata[23:16] == keep, "R9 read byte unchanged", bus_rdata[23:16], keep);
        xfer(1, 8'h0c, 8'h00, 8'h4B, "R9 earlier write done");

        // R2 other offsets and read-only bits
        keep = bus_rdata[23:16];
        bus_write(10'h014, 32'h0100_FF0A);
        bus_addr = 10'h014;
        #1;
        chk(bus_rdata == 32'h0, "R2 other offset reads zero", bus_rdata, 0);
        bus_addr = HOST;
        #1;
        chk(bus_rdata[15:0] == 16'h000C && bus_rdata[24] == 1'b0,
            "R2 other offset ignored", bus_rdata, {keep, 16'h000C});
        bus_write(HOST, 32'h04EE_1207);
        repeat (LAT + 2) @(negedge clk);
        chk(bus_rdata == {8'h00, keep, 16'h1207}, "R2 read-only bits", bus_rdata,
            {8'h00, keep, 16'h1207});

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule